// File: doc/BRIEF.md
# Ramp Histogram Linearity Analyzer

This block builds a per-code occurrence histogram from a converter whose input is swept by a slow linear ramp while it samples at a fixed rate. Each accepted sample increments the bin of its code. Because the ramp spends time in each code in proportion to the code's width, a bin's count measures that width. A start command empties every bin and opens the capture window. A capture-end command closes it and launches an analysis pass.

The analysis pass walks the inner codes in ascending order, one code at a time. For each code it divides the scaled hit count by the inner-code total, using a sequential divider. This gives the code width in LSB units as fixed point with `FRAC_W` fractional bits. It then forms the endpoint DNL and keeps a running INL total. Each code's index, hit count, DNL, INL and a missing-code flag come out on a one-cycle result strobe. When the pass ends, a verdict, a sticky missing-code indicator and the index of the code with the largest |DNL| are available.

The controller has five states. IDLE waits. CAPTURE counts samples. DIVIDE waits for the divider. EMIT presents one result. FINISH marks the end of the pass. The transitions are: `start_i` from any state goes to CAPTURE. `done_i` in CAPTURE goes to DIVIDE. Divider completion goes from DIVIDE to EMIT. EMIT returns to DIVIDE for the next code, or goes to FINISH after the highest inner code. FINISH returns to IDLE.

Top module: `lha_analyzer`

## Requirements
- R1: After reset the block is in IDLE: `res_valid_o`, `done_o`, `fail_o` and `missing_any_o` are 0.
- R2: `start_i` clears every bin and enters CAPTURE. In CAPTURE, each cycle with `smp_valid_i` high adds one to the bin of `smp_code_i`.
- R3: A bin that holds 2^CNT_W−1 keeps that value on further hits; it never wraps.
- R4: Code 0 and code 2^CODE_W−1 are never reported, and their hits take no part in the total S.
- R5: With K = 2^CODE_W−2 and S the sum of the inner bins, width = floor(hits·K·2^FRAC_W / S). When S = 0 the width is 0.
- R6: `res_dnl_o` is the signed value width − 2^FRAC_W.
- R7: `res_inl_o` is the running sum of DNL over the codes reported so far, starting from 0 at code 1.
- R8: `res_missing_o` is 1 exactly when width < `miss_thr_i`. `missing_any_o` is 1 after a pass in which any code was flagged.
- R9: `fail_o` is set when any reported |DNL| > `dnl_lim_i` or |INL| > `inl_lim_i`. It holds until the next `start_i`.
- R10: `worst_code_o` is the lowest-index inner code with the greatest |DNL| in the pass.
- R11: Samples that arrive outside CAPTURE, including during the analysis pass, change no bin.
- R12: After `done_i` in CAPTURE, codes 1 to 2^CODE_W−2 are reported in ascending order, one `res_valid_o` pulse each. A one-cycle `done_o` pulse follows, and the block then returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Clear bins and begin capture |
| smp_valid_i | input | 1 | Sample strobe |
| smp_code_i | input | CODE_W | Sampled code |
| done_i | input | 1 | End capture, start analysis |
| miss_thr_i | input | CODE_W+FRAC_W+1 | Missing-code width threshold (fixed point) |
| dnl_lim_i | input | CODE_W+FRAC_W+1 | Allowed DNL magnitude (fixed point) |
| inl_lim_i | input | CODE_W+FRAC_W+1 | Allowed INL magnitude (fixed point) |
| res_valid_o | output | 1 | Result strobe |
| res_code_o | output | CODE_W | Reported code |
| res_hits_o | output | CNT_W | Bin count of the reported code |
| res_dnl_o | output | CODE_W+FRAC_W+2 | Signed endpoint DNL |
| res_inl_o | output | CODE_W+FRAC_W+3 | Signed endpoint INL |
| res_missing_o | output | 1 | Code width below threshold |
| done_o | output | 1 | End-of-pass pulse |
| fail_o | output | 1 | Limit exceeded in this pass |
| missing_any_o | output | 1 | Some code flagged missing |
| worst_code_o | output | CODE_W | Code with the largest \|DNL\| |

## Verification
The bench targets the following cases.
- End bins that are heavily loaded. A design that let them into S would shift every width.
- A capture with no inner hits. A design that divided by zero would report full-scale widths instead of uniform −1 LSB DNL.
- A bin driven past its ceiling. A wrapping counter would report a tiny width.
- Samples injected while the pass runs. Bins still to be read would then report inflated counts.
- A second capture after a first. Without clearing, old counts would carry over.
- A zero bin. This must produce the missing flag.
- The verdict and worst-code outputs. A sign slip in the magnitude compare would misreport these.

// File: rtl/lha_pkg.sv
`timescale 1ns/1ps
package lha_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAPTURE,
        ST_DIVIDE,
        ST_EMIT,
        ST_FINISH
    } lha_state_t;
endpackage

// File: rtl/lha_bins.sv
`timescale 1ns/1ps
module lha_bins #(
    parameter int CODE_W = 4,
    parameter int CNT_W  = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     inc_i,
    input  logic [CODE_W-1:0]        inc_code_i,
    input  logic [CODE_W-1:0]        rd_addr_i,
    output logic [CNT_W-1:0]         rd_hits_o,
    output logic [CNT_W+CODE_W-1:0]  sum_o
);
    localparam int NB    = 1 << CODE_W;
    localparam int SUM_W = CNT_W + CODE_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] bin_q [NB];
    logic [SUM_W-1:0] sum_q;
    logic             inner_hit;

    assign inner_hit = inc_i && (inc_code_i != '0) && (inc_code_i != {CODE_W{1'b1}})
                       && (bin_q[inc_code_i] != CNT_MAX);

    for (genvar g = 0; g < NB; g++) begin : g_bin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bin_q[g] <= '0;
            else if (clr_i)
                bin_q[g] <= '0;
            else if (inc_i && inc_code_i == CODE_W'(g) && bin_q[g] != CNT_MAX)
                bin_q[g] <= bin_q[g] + 1'b1;
        end

        // R3: a full bin stays full until cleared
        assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i && bin_q[g] == CNT_MAX) |=> bin_q[g] == CNT_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sum_q <= '0;
        else if (clr_i)
            sum_q <= '0;
        else if (inner_hit)
            sum_q <= sum_q + 1'b1;
    end

    assign rd_hits_o = bin_q[rd_addr_i];
    assign sum_o     = sum_q;

    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (sum_q == '0 && bin_q[0] == '0));
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !clr_i) |=> $stable(sum_q));
endmodule

// File: rtl/lha_divider.sv
`timescale 1ns/1ps
module lha_divider #(
    parameter int NUM_W = 24,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [NUM_W-1:0] quo_o
);
    localparam int STEP_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0]  quo_q;
    logic [DEN_W-1:0]  rem_q;
    logic [DEN_W-1:0]  den_q;
    logic [STEP_W-1:0] step_q;
    logic              busy_q;
    logic              done_q;
    logic [DEN_W:0]    shifted;
    logic              fits;

    assign shifted = {rem_q, quo_q[NUM_W-1]};
    assign fits    = shifted >= {1'b0, den_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_q  <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            step_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (start_i) begin
            quo_q  <= num_i;
            rem_q  <= '0;
            den_q  <= den_i;
            step_q <= STEP_W'(NUM_W);
            busy_q <= 1'b1;
            done_q <= 1'b0;
        end else if (busy_q) begin
            rem_q  <= fits ? DEN_W'(shifted - {1'b0, den_q}) : DEN_W'(shifted);
            quo_q  <= {quo_q[NUM_W-2:0], fits};
            step_q <= step_q - 1'b1;
            busy_q <= (step_q != STEP_W'(1));
            done_q <= (step_q == STEP_W'(1));
        end else begin
            done_q <= 1'b0;
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign quo_o  = quo_q;

    // R5: the quotient is handed over in a single-cycle pulse after the run
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
    assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
endmodule

// File: rtl/lha_analyzer.sv
`timescale 1ns/1ps
module lha_analyzer #(
    parameter int CODE_W = 4,
    parameter int CNT_W  = 12,
    parameter int FRAC_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_i,
    input  logic                              smp_valid_i,
    input  logic [CODE_W-1:0]                 smp_code_i,
    input  logic                              done_i,
    input  logic [CODE_W+FRAC_W:0]            miss_thr_i,
    input  logic [CODE_W+FRAC_W:0]            dnl_lim_i,
    input  logic [CODE_W+FRAC_W:0]            inl_lim_i,
    output logic                              res_valid_o,
    output logic [CODE_W-1:0]                 res_code_o,
    output logic [CNT_W-1:0]                  res_hits_o,
    output logic signed [CODE_W+FRAC_W+1:0]   res_dnl_o,
    output logic signed [CODE_W+FRAC_W+2:0]   res_inl_o,
    output logic                              res_missing_o,
    output logic                              done_o,
    output logic                              fail_o,
    output logic                              missing_any_o,
    output logic [CODE_W-1:0]                 worst_code_o
);
    import lha_pkg::*;

    localparam int NB    = 1 << CODE_W;
    localparam int K     = NB - 2;
    localparam int SUM_W = CNT_W + CODE_W;
    localparam int NUM_W = SUM_W + FRAC_W;
    localparam int W_W   = CODE_W + FRAC_W + 1;
    localparam int D_W   = W_W + 1;
    localparam int I_W   = D_W + 1;
    localparam int ONE   = 1 << FRAC_W;
    localparam logic [CODE_W-1:0] FIRST = CODE_W'(1);
    localparam logic [CODE_W-1:0] LAST  = CODE_W'(NB - 2);

    lha_state_t state_q, state_d;

    logic [CODE_W-1:0]     addr_q, rd_addr;
    logic [CNT_W-1:0]      rd_hits, hits_q;
    logic [SUM_W-1:0]      sum;
    logic [NUM_W-1:0]      num, quo;
    logic                  div_start, div_busy, div_done;
    logic [W_W-1:0]        wid, width_q;
    logic signed [D_W-1:0] dnl_n, dnl_q;
    logic signed [I_W-1:0] inl_q, dnl_ext;
    logic [I_W-1:0]        mag_dnl, mag_inl, worst_mag_q;
    logic                  fail_q, miss_any_q;
    logic [CODE_W-1:0]     worst_q;

    // ---------------- histogram storage ----------------
    lha_bins #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_bins (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (start_i),
        .inc_i      (smp_valid_i && state_q == ST_CAPTURE),
        .inc_code_i (smp_code_i),
        .rd_addr_i  (rd_addr),
        .rd_hits_o  (rd_hits),
        .sum_o      (sum)
    );

    // ---------------- per-code normalising divider ----------------
    assign rd_addr   = (state_q == ST_EMIT) ? addr_q + 1'b1 : addr_q;
    assign num       = (NUM_W'(rd_hits) * NUM_W'(K)) << FRAC_W;
    assign div_start = !start_i &&
                       ((state_q == ST_CAPTURE && done_i) ||
                        (state_q == ST_EMIT && addr_q != LAST));

    lha_divider #(.NUM_W(NUM_W), .DEN_W(SUM_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .num_i   (num),
        .den_i   (sum),
        .busy_o  (div_busy),
        .done_o  (div_done),
        .quo_o   (quo)
    );

    assign wid     = (sum == '0) ? '0 : quo[W_W-1:0];
    assign dnl_n   = $signed({1'b0, wid}) - $signed(D_W'(ONE));
    assign dnl_ext = {dnl_q[D_W-1], dnl_q};
    assign mag_dnl = dnl_ext[I_W-1] ? (~dnl_ext + 1'b1) : dnl_ext;
    assign mag_inl = inl_q[I_W-1]   ? (~inl_q + 1'b1)   : inl_q;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = ST_IDLE;
            ST_CAPTURE: if (done_i) state_d = ST_DIVIDE;
            ST_DIVIDE:  if (div_done) state_d = ST_EMIT;
            ST_EMIT:    state_d = (addr_q == LAST) ? ST_FINISH : ST_DIVIDE;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
        if (start_i) state_d = ST_CAPTURE;
    end

    // ---------------- analysis datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q      <= FIRST;
            hits_q      <= '0;
            width_q     <= '0;
            dnl_q       <= '0;
            inl_q       <= '0;
            fail_q      <= 1'b0;
            miss_any_q  <= 1'b0;
            worst_q     <= '0;
            worst_mag_q <= '0;
        end else if (start_i) begin
            addr_q      <= FIRST;
            inl_q       <= '0;
            fail_q      <= 1'b0;
            miss_any_q  <= 1'b0;
            worst_q     <= '0;
            worst_mag_q <= '0;
        end else begin
            if (div_start)
                hits_q <= rd_hits;
            if (state_q == ST_DIVIDE && div_done) begin
                width_q <= wid;
                dnl_q   <= dnl_n;
                inl_q   <= inl_q + {dnl_n[D_W-1], dnl_n};
            end
            if (state_q == ST_EMIT) begin
                addr_q <= addr_q + 1'b1;
                if (mag_dnl > I_W'(dnl_lim_i) || mag_inl > I_W'(inl_lim_i))
                    fail_q <= 1'b1;
                if (width_q < miss_thr_i)
                    miss_any_q <= 1'b1;
                if (addr_q == FIRST || mag_dnl > worst_mag_q) begin
                    worst_q     <= addr_q;
                    worst_mag_q <= mag_dnl;
                end
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        res_valid_o   = (state_q == ST_EMIT);
        done_o        = (state_q == ST_FINISH);
        res_code_o    = addr_q;
        res_hits_o    = hits_q;
        res_dnl_o     = dnl_q;
        res_inl_o     = inl_q;
        res_missing_o = (width_q < miss_thr_i);
        fail_o        = fail_q;
        missing_any_o = miss_any_q;
        worst_code_o  = worst_q;
    end

    assert_no_end_codes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (res_code_o != '0 && res_code_o != {CODE_W{1'b1}}));
    assert_verdict_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !start_i) |=> fail_o);
    assert_single_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);
    assert_end_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (!done_o && !res_valid_o));
    assert_emit_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> !div_busy);
    assert_width_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (div_done && sum != '0) |-> (quo[NUM_W-1:W_W] == '0));
    assert_order_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !start_i && res_code_o != LAST) |=> (res_code_o == $past(res_code_o) + 1'b1));
endmodule

// File: tb/sim_lha_analyzer.sv
`timescale 1ns/1ps
module sim_lha_analyzer;
    localparam int CODE_W = 4;
    localparam int CNT_W  = 12;
    localparam int FRAC_W = 8;
    localparam int NB     = 1 << CODE_W;
    localparam int K      = NB - 2;
    localparam int W_W    = CODE_W + FRAC_W + 1;
    localparam int D_W    = W_W + 1;
    localparam int I_W    = D_W + 1;
    localparam int ONE    = 1 << FRAC_W;
    localparam int CMAX   = (1 << CNT_W) - 1;
    localparam int NPAT   = 4;

    // hit counts per code 0..15, fed as an ascending ramp
    localparam int unsigned PAT [NPAT][NB] = '{
        '{50, 10,10,10,10,10,10,10,10,10,10,10,10,10,10, 50},
        '{7,  10,20,0,10,10,5,10,10,15,10,10,10,10,10,   3},
        '{0,  1,2,3,4,5,6,7,8,9,10,11,12,13,14,          9},
        '{20, 0,0,0,0,0,0,0,0,0,0,0,0,0,0,               20}
    };
    // DNL limit, INL limit, missing threshold (fixed point, 8 fraction bits)
    localparam int unsigned LIM [NPAT][3] = '{
        '{64, 64, 26}, '{200, 300, 26}, '{300, 600, 26}, '{256, 4000, 26}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, smp_valid_i = 1'b0, done_i = 1'b0;
    logic [CODE_W-1:0] smp_code_i = '0;
    logic [W_W-1:0] miss_thr_i = '0, dnl_lim_i = '0, inl_lim_i = '0;
    logic res_valid_o, res_missing_o, done_o, fail_o, missing_any_o;
    logic [CODE_W-1:0] res_code_o, worst_code_o;
    logic [CNT_W-1:0] res_hits_o;
    logic signed [D_W-1:0] res_dnl_o;
    logic signed [I_W-1:0] res_inl_o;

    int n_checks = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    lha_analyzer #(.CODE_W(CODE_W), .CNT_W(CNT_W), .FRAC_W(FRAC_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .smp_valid_i(smp_valid_i),
        .smp_code_i(smp_code_i), .done_i(done_i), .miss_thr_i(miss_thr_i),
        .dnl_lim_i(dnl_lim_i), .inl_lim_i(inl_lim_i), .res_valid_o(res_valid_o),
        .res_code_o(res_code_o), .res_hits_o(res_hits_o), .res_dnl_o(res_dnl_o),
        .res_inl_o(res_inl_o), .res_missing_o(res_missing_o), .done_o(done_o),
        .fail_o(fail_o), .missing_any_o(missing_any_o), .worst_code_o(worst_code_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic run_case(input int unsigned h[NB], input int unsigned dlim,
                            input int unsigned ilim, input int unsigned thr,
                            input bit inject, input string tag);
        longint s, w, d, inl, eh, mag, wmag;
        int n, wcode;
        bit ev_bad, ev_miss;
        int g_code[K], g_hits[K], g_dnl[K], g_inl[K];
        bit g_miss[K];
        bit seen_end;

        dnl_lim_i = W_W'(dlim);
        inl_lim_i = W_W'(ilim);
        miss_thr_i = W_W'(thr);
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        for (int c = 0; c < NB; c++)
            for (int k = 0; k < int'(h[c]); k++) begin
                smp_valid_i = 1'b1;
                smp_code_i = CODE_W'(c);
                tick();
            end
        smp_valid_i = 1'b0;
        done_i = 1'b1;
        tick();
        done_i = 1'b0;

        n = 0;
        seen_end = 1'b0;
        for (int t = 0; t < 4000; t++) begin
            if (inject) begin
                smp_valid_i = 1'b1;
                smp_code_i = (t % 2 == 1) ? CODE_W'(K) : CODE_W'(0);
            end
            tick();
            if (res_valid_o) begin
                if (n < K) begin
                    g_code[n] = int'(res_code_o);
                    g_hits[n] = int'(res_hits_o);
                    g_dnl[n]  = int'(res_dnl_o);
                    g_inl[n]  = int'(res_inl_o);
                    g_miss[n] = res_missing_o;
                end
                n++;
            end
            if (done_o) begin
                seen_end = 1'b1;
                break;
            end
        end
        smp_valid_i = 1'b0;

        check(seen_end, "R12", {tag, " end pulse seen"}, seen_end, 1);
        check(n == K, "R12", {tag, " result count"}, n, K);

        // expected values from the requirements (R2, R3, R4, R5)
        s = 0;
        for (int c = 1; c < NB - 1; c++) s += (h[c] > CMAX) ? CMAX : h[c];
        inl = 0; ev_bad = 0; ev_miss = 0; wcode = 1; wmag = -1;
        for (int i = 0; i < K && i < n; i++) begin
            eh  = (h[i+1] > CMAX) ? CMAX : h[i+1];
            w   = (s == 0) ? 0 : (eh * K * ONE) / s;
            d   = w - ONE;
            inl += d;
            mag = (d < 0) ? -d : d;
            if (mag > wmag) begin wmag = mag; wcode = i + 1; end
            if (mag > dlim || ((inl < 0) ? -inl : inl) > ilim) ev_bad = 1;
            if (w < thr) ev_miss = 1;
            check(g_code[i] == i + 1, "R12", {tag, " code order"}, g_code[i], i + 1);
            check(g_hits[i] == eh, "R2", {tag, " hit count"}, g_hits[i], eh);
            check(g_dnl[i] == d, "R6", {tag, " dnl"}, g_dnl[i], d);
            check(g_inl[i] == inl, "R7", {tag, " inl"}, g_inl[i], inl);
            check(g_miss[i] == (w < thr), "R8", {tag, " missing flag"}, g_miss[i], w < thr);
        end
        check(fail_o == ev_bad, "R9", {tag, " verdict"}, fail_o, ev_bad);
        check(missing_any_o == ev_miss, "R8", {tag, " missing summary"}, missing_any_o, ev_miss);
        check(int'(worst_code_o) == wcode, "R10", {tag, " worst code"}, worst_code_o, wcode);
        tick();
        check(!res_valid_o && !done_o, "R12", {tag, " back to idle"}, res_valid_o, 0);
    endtask

    initial begin : watchdog
        #2000000;
        n_bad++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_bad);
        $finish;
    end

    initial begin : main
        int unsigned h[NB];
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        tick();
        // R1: reset state
        check(!res_valid_o, "R1", "valid after reset", res_valid_o, 0);
        check(!done_o, "R1", "done after reset", done_o, 0);
        check(!fail_o, "R1", "verdict after reset", fail_o, 0);
        check(!missing_any_o, "R1", "missing after reset", missing_any_o, 0);

        // table walk: each new capture must clear the previous bins (R2);
        // loaded end bins must not move widths (R4); empty inner set gives width 0 (R5)
        for (int p = 0; p < NPAT; p++) begin
            for (int c = 0; c < NB; c++) h[c] = PAT[p][c];
            run_case(h, LIM[p][0], LIM[p][1], LIM[p][2], 1'b0, $sformatf("pattern%0d", p));
        end

        // R11: samples during the analysis pass are ignored
        for (int c = 0; c < NB; c++) h[c] = PAT[1][c];
        run_case(h, LIM[1][0], LIM[1][1], LIM[1][2], 1'b1, "inject_R11");

        // R3: bin saturates instead of wrapping
        for (int c = 0; c < NB; c++) h[c] = 1;
        h[5] = CMAX + 5;
        run_case(h, 4000, 4000, 26, 1'b0, "saturate_R3");

        // R11: samples outside capture (idle) do not enter bins
        smp_valid_i = 1'b1;
        smp_code_i = CODE_W'(3);
        repeat (8) tick();
        smp_valid_i = 1'b0;
        for (int c = 0; c < NB; c++) h[c] = PAT[0][c];
        run_case(h, LIM[0][0], LIM[0][1], LIM[0][2], 1'b0, "idle_samples_R11");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_bad);
        $finish;
    end
endmodule